// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models the target side of a three-wire serial nonvolatile memory. A host selects it with a chip-select line, clocks it with a serial clock, sends commands on a data-in line and receives data and status on a data-out line. The data-out line has a separate enable, and the enable is low whenever the line would be high impedance. All three host pins are synchronized into the system clock, and every action takes place on a detected rising edge of the serial clock while chip-select is high.

The storage is a register array of `2**AW` words of `DW` bits. The default is 64 words of 16 bits, and `AW = 7` gives the 128-word variant. A command is a start bit, a 2-bit op code and an `AW`-bit address, sent MSB first. Reads run on across word boundaries for as long as the clock keeps going. The write-type commands are single write, single erase, fill-all and erase-all. Each one is gated by a program-enable latch. A write-type command starts a program cycle of `PROG_CYCLES` system clocks, and the host can poll its progress on data-out.

Top module: `serial_eeprom_target`

## Requirements
- R1: After reset the data-out enable is low, every word reads as all ones, and the program-enable latch is clear.
- R2: While chip-select is high, serial-clock rising edges that sample data-in low before the first high sample are ignored. The first high sample is the start bit.
- R3: The command bits after the start bit are a 2-bit op code and then the address, both MSB first. Op code 10 is a read. On the edge that samples the last address bit, data-out becomes enabled and drives 0. The edges that follow present the addressed word MSB first.
- R4: During a read, the edge after a word's last bit presents the MSB of the word at the next address. The next address after the highest one is address 0.
- R5: Op code 01 is a write. It takes 16 data bits MSB first after the address, and bits after the 16th are ignored. The word is stored when chip-select falls. The store lasts one system-clock pulse and is followed by the busy period.
- R6: If chip-select falls before the 16th data bit of a write, nothing is stored and no busy period starts.
- R7: Op code 11 sets the addressed word to all ones when chip-select falls.
- R8: Op code 00 is an extended command, selected by the two top address bits. Value 01 stores the 16 data bits that follow in every word. Value 10 sets every word to all ones.
- R9: With op code 00, top address bits 11 set the program-enable latch and 00 clear it. A write-type command received while the latch is clear completes its transfer but changes no word and starts no busy period.
- R10: For `PROG_CYCLES` system clocks after a program starts, chip-select high enables data-out with value 0 (busy), and serial-clock and data-in activity is ignored.
- R11: After the program cycle, chip-select high shows data-out enabled at 1 (ready). A start bit received then disables data-out and begins a new command.
- R12: Data-out is disabled whenever the synchronized chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip-select from the host, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data or status to the host |
| do_oe_o | output | 1 | Enable for do_o; low means high impedance |

## Verification
The hardest state to reach from the pins is the ready phase right after a program cycle. To show that a start bit there is accepted and also ends the status display, the bench must raise chip-select while the cycle is still running. It then pulses the serial clock with data-in high during busy, to show those edges are dropped. It polls until the line turns ready, sends a fresh start bit, and finishes a complete read in the same chip-select window. Each cancel case is followed by a reselect that checks no busy status appears, and then by a readback.

// File: rtl/sep_pkg.sv
package sep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RD,
        ST_WD,
        ST_DONE,
        ST_PROG,
        ST_READY
    } sep_state_e;

    // two-bit op code following the start bit
    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    // extended command selector: top two address bits
    localparam logic [1:0] EX_LOCK  = 2'b00;
    localparam logic [1:0] EX_FILL  = 2'b01;
    localparam logic [1:0] EX_WIPE  = 2'b10;
    localparam logic [1:0] EX_OPEN  = 2'b11;

endpackage

// File: rtl/sep_sync.sv
module sep_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= in_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign out_o = stage_q[STAGES-1];
endmodule

// File: rtl/sep_store.sv
module sep_store #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          wr_all_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);
    localparam int WORDS = 1 << AW;

    logic [WORDS*DW-1:0] flat;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [DW-1:0] cell_q;
        logic          hit;

        assign hit = wr_i && (wr_all_i || (wr_addr_i == AW'(i)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '1;
            end else if (hit) begin
                cell_q <= wr_data_i;
            end
        end

        assign flat[i*DW +: DW] = cell_q;
    end

    assign rd_data_o = flat[rd_addr_i*DW +: DW];
endmodule

// File: rtl/sep_ctrl.sv
module sep_ctrl
    import sep_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s_i,
    input  logic          sk_rise_i,
    input  logic          di_s_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          mem_wr_o,
    output logic          mem_all_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_data_o,
    output logic          do_o,
    output logic          do_oe_o,
    output logic          we_o,
    output logic          busy_o
);
    localparam int HW  = 2 + AW;
    localparam int CW  = $clog2(HW + DW);
    localparam int OCW = $clog2(DW + 1);
    localparam int PW  = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        sep_state_e     st;
        logic [CW-1:0]  bitcnt;
        logic [HW-1:0]  hdr;
        logic [DW-1:0]  wd;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  osh;
        logic           obit;
        logic [OCW-1:0] ocnt;
        logic           we;
        logic           armed;
        logic           job_all;
        logic [DW-1:0]  job_data;
        logic [PW-1:0]  pcnt;
        logic           mwr;
    } ctrl_t;

    ctrl_t         q, d;
    logic [HW-1:0] hdr_full;
    logic [1:0]    full_op;
    logic [1:0]    full_ext;
    logic [AW-1:0] full_addr;
    logic [DW-1:0] wd_full;
    logic [DW-1:0] word;

    assign hdr_full  = {q.hdr[HW-2:0], di_s_i};
    assign full_op   = hdr_full[HW-1:HW-2];
    assign full_addr = hdr_full[AW-1:0];
    assign full_ext  = hdr_full[AW-1:AW-2];
    assign wd_full   = {q.wd[DW-2:0], di_s_i};
    assign word      = (q.ocnt == OCW'(DW)) ? rd_data_i : q.osh;

    always_comb begin
        d     = q;
        d.mwr = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (sk_rise_i && di_s_i) begin
                    d.st     = ST_CMD;
                    d.bitcnt = '0;
                end
            end
            ST_CMD: begin
                if (!cs_s_i) begin
                    d.st = ST_IDLE;
                end else if (sk_rise_i) begin
                    d.hdr    = hdr_full;
                    d.bitcnt = q.bitcnt + 1'b1;
                    if (q.bitcnt == CW'(HW - 1)) begin
                        d.bitcnt = '0;
                        d.armed  = 1'b0;
                        d.addr   = full_addr;
                        d.st     = ST_DONE;
                        unique case (full_op)
                            OP_READ: begin
                                d.st   = ST_RD;
                                d.osh  = rd_data_i;
                                d.obit = 1'b0;
                                d.ocnt = '0;
                            end
                            OP_WRITE: begin
                                d.st      = ST_WD;
                                d.job_all = 1'b0;
                            end
                            OP_ERASE: begin
                                d.armed    = q.we;
                                d.job_all  = 1'b0;
                                d.job_data = '1;
                            end
                            default: begin
                                unique case (full_ext)
                                    EX_FILL: begin
                                        d.st      = ST_WD;
                                        d.job_all = 1'b1;
                                    end
                                    EX_WIPE: begin
                                        d.armed    = q.we;
                                        d.job_all  = 1'b1;
                                        d.job_data = '1;
                                    end
                                    EX_OPEN: d.we = 1'b1;
                                    default: d.we = 1'b0;
                                endcase
                            end
                        endcase
                    end
                end
            end
            ST_WD: begin
                if (!cs_s_i) begin
                    d.st = ST_IDLE;
                end else if (sk_rise_i) begin
                    d.wd     = wd_full;
                    d.bitcnt = q.bitcnt + 1'b1;
                    if (q.bitcnt == CW'(DW - 1)) begin
                        d.st       = ST_DONE;
                        d.armed    = q.we;
                        d.job_data = wd_full;
                    end
                end
            end
            ST_RD: begin
                if (!cs_s_i) begin
                    d.st = ST_IDLE;
                end else if (sk_rise_i) begin
                    d.obit = word[DW-1];
                    d.osh  = {word[DW-2:0], 1'b0};
                    if (q.ocnt == OCW'(DW)) begin
                        d.addr = q.addr + 1'b1;
                        d.ocnt = OCW'(1);
                    end else begin
                        d.ocnt = q.ocnt + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                if (!cs_s_i) begin
                    if (q.armed) begin
                        d.st   = ST_PROG;
                        d.mwr  = 1'b1;
                        d.pcnt = PW'(PROG_CYCLES - 1);
                    end else begin
                        d.st = ST_IDLE;
                    end
                    d.armed = 1'b0;
                end
            end
            ST_PROG: begin
                if (q.pcnt == '0) begin
                    d.st = cs_s_i ? ST_READY : ST_IDLE;
                end else begin
                    d.pcnt = q.pcnt - 1'b1;
                end
            end
            ST_READY: begin
                if (!cs_s_i) begin
                    d.st = ST_IDLE;
                end else if (sk_rise_i && di_s_i) begin
                    d.st     = ST_CMD;
                    d.bitcnt = '0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rd_addr_o  = (q.st == ST_CMD) ? full_addr : q.addr + 1'b1;
    assign mem_wr_o   = q.mwr;
    assign mem_all_o  = q.job_all;
    assign mem_addr_o = q.addr;
    assign mem_data_o = q.job_data;
    assign do_oe_o    = cs_s_i && (q.st == ST_RD || q.st == ST_PROG || q.st == ST_READY);
    assign do_o       = (q.st == ST_RD) ? q.obit : (q.st == ST_READY);
    assign we_o       = q.we;
    assign busy_o     = (q.st == ST_PROG);
endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target #(
    parameter int AW          = 6,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);
    logic [2:0]    pins_s;
    logic          cs_s, sk_s, di_s;
    logic          sk_p_q;
    logic          sk_rise;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          mem_wr, mem_all;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          we_lat, busy;

    sep_sync #(.W(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  ({cs_i, sk_i, di_i}),
        .out_o (pins_s)
    );

    assign {cs_s, sk_s, di_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_p_q <= 1'b0;
        else        sk_p_q <= sk_s;
    end

    assign sk_rise = sk_s && !sk_p_q && cs_s;

    sep_ctrl #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s_i    (cs_s),
        .sk_rise_i (sk_rise),
        .di_s_i    (di_s),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .mem_wr_o  (mem_wr),
        .mem_all_o (mem_all),
        .mem_addr_o(mem_addr),
        .mem_data_o(mem_data),
        .do_o      (do_o),
        .do_oe_o   (do_oe_o),
        .we_o      (we_lat),
        .busy_o    (busy)
    );

    sep_store #(.AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (mem_wr),
        .wr_all_i  (mem_all),
        .wr_addr_i (mem_addr),
        .wr_data_i (mem_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );
endmodule

// File: rtl/sep_chk.sv
module sep_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic oe,
    input logic mem_wr,
    input logic we,
    input logic busy
);
    // R12: a deselected target never drives the line
    p_standby_hiz_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |-> !oe);

    // R9: a store only happens with program-enable set
    p_locked_no_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> we);

    // R10: every store is followed by a busy period (PROG_CYCLES >= 2)
    p_store_then_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> busy);

    // R5: the store strobe lasts a single system clock
    p_store_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);
endmodule

bind serial_eeprom_target sep_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_s   (cs_s),
    .oe     (do_oe_o),
    .mem_wr (mem_wr),
    .we     (we_lat),
    .busy   (busy)
);

// File: tb/serial_eeprom_target_bench.sv
module serial_eeprom_target_bench;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, doe;
    int   checks = 0;
    int   errors = 0;
    logic [15:0] exp_mem [64];

    always #5 clk = ~clk;

    serial_eeprom_target u_serial_eeprom_target (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .do_o(dout), .do_oe_o(doe)
    );

    // {address, data}: write then read back (R5)
    localparam logic [21:0] VEC [6] = '{
        {6'd0,  16'hA5C3}, {6'd63, 16'h0001}, {6'd17, 16'h8000},
        {6'd42, 16'hFFFE}, {6'd1,  16'h5A5A}, {6'd30, 16'h0F0F}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sk_bit(input logic b, output logic ob, output logic ooe);
        di = b;
        repeat (H) @(negedge clk);
        sk = 1'b1;
        repeat (H) @(negedge clk);
        ob = dout;
        ooe = doe;
        sk = 1'b0;
    endtask

    task automatic cs_up();
        cs = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_dn();
        cs = 1'b0;
        di = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [5:0] a, input int ndummy,
                            input logic with_start, output logic lo, output logic loe);
        for (int i = 0; i < ndummy; i++) sk_bit(1'b0, lo, loe);
        if (with_start) sk_bit(1'b1, lo, loe);
        for (int i = 1; i >= 0; i--) sk_bit(op[i], lo, loe);
        for (int i = 5; i >= 0; i--) sk_bit(a[i], lo, loe);
    endtask

    task automatic read_words(input logic [5:0] a, input int nw, input string tag);
        logic [15:0] w;
        logic o, e;
        for (int k = 0; k < nw; k++) begin
            for (int i = 15; i >= 0; i--) begin
                sk_bit(1'b0, o, e);
                w[i] = o;
            end
            check(tag, {16'd0, w}, {16'd0, exp_mem[6'(a + k)]});
        end
    endtask

    task automatic do_read(input logic [5:0] a, input int nw, input int ndummy, input string tag);
        logic o, e;
        cs_up();
        send_hdr(2'b10, a, ndummy, 1'b1, o, e);
        check({tag, " lead zero R3"}, {30'd0, e, o}, 32'd2);
        read_words(a, nw, tag);
        cs_dn();
    endtask

    task automatic do_write(input logic [1:0] op, input logic [5:0] a,
                            input logic [15:0] data, input int nbits);
        logic o, e;
        cs_up();
        send_hdr(op, a, 0, 1'b1, o, e);
        for (int i = 0; i < nbits; i++) sk_bit((i < 16) ? data[15-i] : 1'b1, o, e);
        cs_dn();
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        cs_up();
        while (!(doe && dout) && n < 200) begin
            repeat (4) @(negedge clk);
            n++;
        end
        check(tag, {30'd0, doe, dout}, 32'd3);
        cs_dn();
    endtask

    task automatic no_busy(input string tag);
        cs = 1'b1;
        repeat (6) @(negedge clk);
        check(tag, {31'd0, doe}, 32'd0);
        cs_dn();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic o, e;
        for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check("R1 oe after reset", {31'd0, doe}, 32'd0);
        do_read(6'd0, 1, 0, "R1 erased word");

        // R9: locked write has no effect
        do_write(2'b01, 6'd5, 16'h1234, 16);
        no_busy("R9 locked write no busy");
        do_read(6'd5, 1, 0, "R9 locked word kept");

        // R9: open for programming
        cs_up();
        send_hdr(2'b00, 6'b110000, 0, 1'b1, o, e);
        cs_dn();

        // R5: table of writes with readback
        for (int v = 0; v < 6; v++) begin
            do_write(2'b01, VEC[v][21:16], VEC[v][15:0], 16);
            exp_mem[VEC[v][21:16]] = VEC[v][15:0];
            wait_ready("R5 ready after write");
            do_read(VEC[v][21:16], 1, 0, "R5 readback");
        end

        // R4: wrap from top address to 0
        do_read(6'd63, 2, 0, "R4 sequential wrap");
        do_read(6'd29, 3, 0, "R4 sequential run");

        // R2: dummy cycles before the start bit
        do_read(6'd17, 1, 3, "R2 dummy cycles");

        // R5: bits beyond the sixteenth ignored
        do_write(2'b01, 6'd9, 16'h1357, 19);
        exp_mem[9] = 16'h1357;
        wait_ready("R5 ready after long write");
        do_read(6'd9, 1, 0, "R5 extra bits ignored");

        // R6: cancelled write
        do_write(2'b01, 6'd9, 16'h0000, 15);
        no_busy("R6 cancel no busy");
        do_read(6'd9, 1, 0, "R6 word kept");

        // R7: single erase
        do_write(2'b11, 6'd17, 16'h0000, 0);
        exp_mem[17] = 16'hFFFF;
        wait_ready("R7 ready after erase");
        do_read(6'd17, 1, 0, "R7 erased");

        // R10 / R11: busy status, ignored clocks, ready, start bit resumes
        do_write(2'b01, 6'd20, 16'h2468, 16);
        exp_mem[20] = 16'h2468;
        cs = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 busy status", {30'd0, doe, dout}, 32'd2);
        sk_bit(1'b1, o, e);
        check("R10 clock ignored while busy", {30'd0, e, o}, 32'd2);
        begin
            int n = 0;
            while (!(doe && dout) && n < 200) begin
                repeat (4) @(negedge clk);
                n++;
            end
        end
        check("R11 ready status", {30'd0, doe, dout}, 32'd3);
        sk_bit(1'b1, o, e);
        check("R11 start bit ends status", {31'd0, e}, 32'd0);
        send_hdr(2'b10, 6'd20, 0, 1'b0, o, e);
        check("R11 read lead zero", {30'd0, e, o}, 32'd2);
        read_words(6'd20, 1, "R11 read after ready");
        cs_dn();
        check("R12 deselect hiz", {31'd0, doe}, 32'd0);

        // R8: fill all
        do_write(2'b00, 6'b010000, 16'hBEEF, 16);
        for (int i = 0; i < 64; i++) exp_mem[i] = 16'hBEEF;
        wait_ready("R8 ready after fill");
        do_read(6'd63, 2, 0, "R8 fill all");

        // R8: erase all
        do_write(2'b00, 6'b100000, 16'h0000, 0);
        for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
        wait_ready("R8 ready after erase all");
        do_read(6'd33, 1, 0, "R8 erase all");

        // R9: lock again
        cs_up();
        send_hdr(2'b00, 6'b000000, 0, 1'b1, o, e);
        cs_dn();
        do_write(2'b01, 6'd3, 16'h1111, 16);
        no_busy("R9 relocked no busy");
        do_read(6'd3, 1, 0, "R9 relocked word kept");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule